// File: doc/BRIEF.md
# Event-Driven Membrane Accumulator Array

This block models one layer of a spiking network whose synaptic weights and neuron membrane potentials live in a single shared storage array. Word 0 of the array holds the potential of every neuron. Words 1 to N_IN each hold the weight row of one input. Every word is split into N_NEU lanes of W_P bits. Lane j of any word belongs to neuron j, so a weight and the potential it feeds share the same bit column. Weights arrive at the narrower width W_W and are stored sign-extended across their lane.

The layer only does work when an event arrives. Each accepted input spike reads that input's weight row, reads the potential word, and writes back the saturated sums. When the timestep strobe is accepted, the block reads the potentials once. It compares each potential with a threshold and applies the reset or leak rule chosen by the mode input. It then writes the potentials back and presents the output spike vector with a one-cycle valid pulse. A single ready output applies back-pressure to spike events and timestep strobes while a sequence is running, and while a weight is being loaded.

Top module: `macc_array`

## Requirements
- R1: After reset, every storage word is zero, `acc_ready` is 1, `out_vld` is 0 and `out_spk` is 0. A timestep taken before any spike therefore emits no spike for any positive threshold.
- R2: A cycle with `wl_valid` high while the block is idle writes `wl_data`, sign-extended, into lane `wl_lane` of the weight row for input `wl_row`. During that cycle `acc_ready` is 0. The loaded weight affects neuron `wl_lane` only.
- R3: Each accepted spike on input i adds weight (i, j) to the potential of every neuron j.
- R4: Potentials are signed W_P-bit values. A sum that passes the largest or smallest value is clamped to that value and does not wrap.
- R5: An accepted spike keeps `acc_ready` low for exactly 3 cycles: one to read the weight row, one to read the potentials, one to write them back. A timestep with no spikes costs no accumulation cycles.
- R6: A timestep accepted on clock edge k raises `out_vld` for one cycle after edge k+2. Bit j of `out_spk` is 1 when potential j is greater than or equal to `cfg_thr` (signed). `out_spk` holds its value until the next timestep result.
- R7: With `cfg_mode`=0 (integrate-and-fire), a neuron that fires is set to 0 and a neuron that does not fire keeps its potential.
- R8: With `cfg_mode`=1 (leaky), a neuron that fires is set to 0. A neuron that does not fire becomes p - (p >>> `cfg_leak`), using an arithmetic shift.
- R9: With `cfg_mode`=2 (reset by subtraction), a neuron that fires has `cfg_thr` subtracted from its potential. A neuron that does not fire is unchanged.
- R10: While a timestep evaluation runs, `acc_ready` stays low and pending spikes wait. When a spike and a timestep are both offered in the idle state, the spike is taken first.
- R11: `cfg_mode`=3 behaves exactly like integrate-and-fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Neuron rule: 0 IF, 1 leaky IF, 2 reset by subtraction, 3 same as 0 |
| cfg_leak | input | SH_W | Leak shift amount for mode 1 |
| cfg_thr | input | W_P | Signed firing threshold, expected to be positive |
| wl_valid | input | 1 | Weight load strobe |
| wl_row | input | IDX_W | Input index of the weight being loaded |
| wl_lane | input | LANE_W | Neuron index of the weight being loaded |
| wl_data | input | W_W | Signed weight value |
| ev_valid | input | 1 | Input spike event offered |
| ev_idx | input | IDX_W | Index of the spiking input |
| ts_valid | input | 1 | Timestep-end strobe offered |
| acc_ready | output | 1 | Block idle and able to accept a spike or a timestep |
| out_vld | output | 1 | One-cycle pulse marking a new spike vector |
| out_spk | output | N_NEU | Output spikes of the last timestep |

## Verification
On every cycle, the assertions check the following:
- The 3-cycle busy window after a spike.
- The 2-cycle latency and single-cycle width of `out_vld`.
- That `out_spk` stays stable between results.
- That each lane's saturating sum moves in the direction of the weight's sign.
- That the evaluation step never increases a potential's magnitude while the threshold is positive.

Only the bench scenarios can show the arithmetic values themselves. These are the accumulated sums against a reference model, clamping at both limits, and the distinct reset and leak outcomes of each mode. They also include column-exact weight placement and the spike-before-step ordering under contention.

// File: rtl/macc_pkg.sv
package macc_pkg;
   // Neuron rule selector; code 3 is decoded like code 0
   typedef enum logic [1:0] {
      NM_IF  = 2'd0,
      NM_LIF = 2'd1,
      NM_RMP = 2'd2,
      NM_ALT = 2'd3
   } nmode_e;

   // Sequencer states shared by spike and timestep paths
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRD,
      ST_PRD,
      ST_WB,
      ST_ERD,
      ST_EWB
   } seq_e;
endpackage

// File: rtl/macc_lane_acc.sv
module macc_lane_acc #(
   parameter int W_P = 10
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [W_P-1:0] w,
   input  logic [W_P-1:0] pot,
   output logic [W_P-1:0] sum
);
   localparam logic [W_P-1:0] P_MAX = {1'b0, {(W_P-1){1'b1}}};
   localparam logic [W_P-1:0] P_MIN = {1'b1, {(W_P-1){1'b0}}};

   logic [W_P:0] wide;

   always_comb begin
      wide = {pot[W_P-1], pot} + {w[W_P-1], w};
      if (wide[W_P] != wide[W_P-1])
         sum = wide[W_P] ? P_MIN : P_MAX;
      else
         sum = wide[W_P-1:0];
   end

   // R4
   sat_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      w[W_P-1] ? ($signed(sum) <= $signed(pot)) : ($signed(sum) >= $signed(pot)));
endmodule

// File: rtl/macc_lane_fire.sv
module macc_lane_fire
   import macc_pkg::*;
#(
   parameter int W_P  = 10,
   parameter int SH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [1:0]      mode,
   input  logic [SH_W-1:0] leak,
   input  logic [W_P-1:0]  thr,
   input  logic [W_P-1:0]  pot,
   output logic [W_P-1:0]  nxt,
   output logic            fire
);
   nmode_e               md;
   logic signed [W_P-1:0] sp, st, shr;

   always_comb begin
      md   = nmode_e'(mode);
      sp   = $signed(pot);
      st   = $signed(thr);
      shr  = sp >>> leak;
      fire = (sp >= st);
      if (fire)
         nxt = (md == NM_RMP) ? W_P'(sp - st) : '0;
      else
         nxt = (md == NM_LIF) ? W_P'(sp - shr) : pot;
   end

   // magnitudes for the decay property
   logic signed [W_P:0] xo, xn;
   logic        [W_P:0] mag_o, mag_n;
   always_comb begin
      xo    = {pot[W_P-1], pot};
      xn    = {nxt[W_P-1], nxt};
      mag_o = (xo < 0) ? W_P'(0) - xo : xo;
      mag_n = (xn < 0) ? W_P'(0) - xn : xn;
   end

   // R8 R9
   decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(thr) > 0) |-> (mag_n <= mag_o));
endmodule

// File: rtl/macc_array.sv
module macc_array
   import macc_pkg::*;
#(
   parameter  int N_IN   = 4,
   parameter  int N_NEU  = 4,
   parameter  int W_W    = 6,
   parameter  int W_P    = 10,
   parameter  int SH_W   = 3,
   localparam int IDX_W  = (N_IN  > 1) ? $clog2(N_IN)  : 1,
   localparam int LANE_W = (N_NEU > 1) ? $clog2(N_NEU) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_mode,
   input  logic [SH_W-1:0]   cfg_leak,
   input  logic [W_P-1:0]    cfg_thr,
   input  logic              wl_valid,
   input  logic [IDX_W-1:0]  wl_row,
   input  logic [LANE_W-1:0] wl_lane,
   input  logic [W_W-1:0]    wl_data,
   input  logic              ev_valid,
   input  logic [IDX_W-1:0]  ev_idx,
   input  logic              ts_valid,
   output logic              acc_ready,
   output logic              out_vld,
   output logic [N_NEU-1:0]  out_spk
);
   localparam int DEPTH  = N_IN + 1;
   localparam int AW     = $clog2(DEPTH);
   localparam int WORD_W = N_NEU * W_P;

   // elaboration checks on the parameter set
   if (W_W < 2 || W_W > W_P) begin : g_bad_width
      $error("weight width must be in 2..W_P");
   end
   if ((1 << IDX_W) != N_IN || (1 << LANE_W) != N_NEU) begin : g_bad_count
      $error("input and neuron counts must be powers of two");
   end

   // shared array: word 0 potentials, word i+1 weight row of input i
   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] wrow_q, prow_q, sum_w, nxt_w;
   logic [N_NEU-1:0]  fire_w;
   logic [IDX_W-1:0]  idx_q;
   logic [W_P-1:0]    wl_ext;
   seq_e              state;

   assign wl_ext    = W_P'($signed(wl_data));
   assign acc_ready = (state == ST_IDLE) && !wl_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         idx_q   <= '0;
         wrow_q  <= '0;
         prow_q  <= '0;
         out_vld <= 1'b0;
         out_spk <= '0;
         for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      end else begin
         out_vld <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (wl_valid)
                  mem[AW'(wl_row) + AW'(1)][wl_lane*W_P +: W_P] <= wl_ext;
               else if (ev_valid) begin
                  idx_q <= ev_idx;
                  state <= ST_WRD;
               end else if (ts_valid)
                  state <= ST_ERD;
            end
            ST_WRD: begin
               wrow_q <= mem[AW'(idx_q) + AW'(1)];
               state  <= ST_PRD;
            end
            ST_PRD: begin
               prow_q <= mem[0];
               state  <= ST_WB;
            end
            ST_WB: begin
               mem[0] <= sum_w;
               state  <= ST_IDLE;
            end
            ST_ERD: begin
               prow_q <= mem[0];
               state  <= ST_EWB;
            end
            ST_EWB: begin
               mem[0]  <= nxt_w;
               out_spk <= fire_w;
               out_vld <= 1'b1;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // one accumulate lane and one fire lane per neuron column
   for (genvar g = 0; g < N_NEU; g++) begin : g_lane
      macc_lane_acc #(.W_P(W_P)) u_acc (
         .clk (clk),
         .rst_n (rst_n),
         .w   (wrow_q[g*W_P +: W_P]),
         .pot (prow_q[g*W_P +: W_P]),
         .sum (sum_w[g*W_P +: W_P])
      );
      macc_lane_fire #(.W_P(W_P), .SH_W(SH_W)) u_fire (
         .clk  (clk),
         .rst_n (rst_n),
         .mode (cfg_mode),
         .leak (cfg_leak),
         .thr  (cfg_thr),
         .pot  (prow_q[g*W_P +: W_P]),
         .nxt  (nxt_w[g*W_P +: W_P]),
         .fire (fire_w[g])
      );
   end

   logic ev_take, ts_take;
   assign ev_take = acc_ready && ev_valid;
   assign ts_take = acc_ready && !ev_valid && ts_valid;

   // R5
   spike_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_take |=> !acc_ready ##1 !acc_ready ##1 !acc_ready);
   // R6
   step_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_take |=> !out_vld ##1 !out_vld ##1 out_vld);
   // R6
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_vld |=> !out_vld);
   // R6
   spk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_vld |-> $stable(out_spk));
endmodule

// File: tb/tb_macc_array.sv
module tb_macc_array;
   localparam int N_IN = 4, N_NEU = 4, W_W = 6, W_P = 10, SH_W = 3;
   localparam int PMAX = (1 << (W_P-1)) - 1;
   localparam int PMIN = -(1 << (W_P-1));

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n;
   logic [1:0]      cfg_mode;
   logic [SH_W-1:0] cfg_leak;
   logic [W_P-1:0]  cfg_thr;
   logic            wl_valid;
   logic [1:0]      wl_row, wl_lane;
   logic [W_W-1:0]  wl_data;
   logic            ev_valid;
   logic [1:0]      ev_idx;
   logic            ts_valid;
   logic            ev_ready;
   logic            out_vld;
   logic [N_NEU-1:0] out_spk;

   macc_array #(.N_IN(N_IN), .N_NEU(N_NEU), .W_W(W_W), .W_P(W_P), .SH_W(SH_W)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_leak(cfg_leak), .cfg_thr(cfg_thr),
      .wl_valid(wl_valid), .wl_row(wl_row), .wl_lane(wl_lane), .wl_data(wl_data),
      .ev_valid(ev_valid), .ev_idx(ev_idx), .ts_valid(ts_valid), .acc_ready(ev_ready),
      .out_vld(out_vld), .out_spk(out_spk)
   );

   int checks = 0, fails = 0;
   int pm [N_NEU];
   int wm [N_IN][N_NEU];

   typedef struct packed {
      logic [1:0]     md;
      logic [2:0]     lk;
      logic [W_P-1:0] th;
      logic [3:0]     msk;
      logic [1:0]     rp;
   } vec_t;

   localparam vec_t TBL [8] = '{
      '{2'd0, 3'd0, 10'd5,  4'b0011, 2'd1},
      '{2'd0, 3'd0, 10'd8,  4'b1111, 2'd2},
      '{2'd1, 3'd1, 10'd12, 4'b0101, 2'd2},
      '{2'd1, 3'd2, 10'd6,  4'b1110, 2'd1},
      '{2'd1, 3'd0, 10'd9,  4'b1001, 2'd1},
      '{2'd2, 3'd0, 10'd7,  4'b1111, 2'd3},
      '{2'd2, 3'd0, 10'd7,  4'b0000, 2'd1},
      '{2'd3, 3'd0, 10'd4,  4'b0110, 2'd2}
   };

   function automatic int sat(int v);
      if (v > PMAX) return PMAX;
      if (v < PMIN) return PMIN;
      return v;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   task automatic clear_model();
      foreach (pm[j]) pm[j] = 0;
      foreach (wm[i, j]) wm[i][j] = 0;
   endtask

   task automatic load_w(int r, int l, int v);
      @(negedge clk);
      wl_valid = 1'b1; wl_row = 2'(r); wl_lane = 2'(l); wl_data = W_W'(v);
      #1 chk(ev_ready == 1'b0, "R2 ready during load", int'(ev_ready), 0);
      @(negedge clk);
      wl_valid = 1'b0;
      wm[r][l] = v;
   endtask

   task automatic spike(int i);
      int lo;
      @(negedge clk);
      ev_valid = 1'b1; ev_idx = 2'(i);
      while (!ev_ready) @(negedge clk);
      @(negedge clk);
      ev_valid = 1'b0;
      lo = 0;
      while (!ev_ready) begin lo++; @(negedge clk); end
      chk(lo == 3, "R5 busy cycles per spike", lo, 3);
      for (int j = 0; j < N_NEU; j++) pm[j] = sat(pm[j] + wm[i][j]);
   endtask

   function automatic logic [N_NEU-1:0] model_step(int md, int lk, int th);
      logic [N_NEU-1:0] e = '0;
      for (int j = 0; j < N_NEU; j++) begin
         if (pm[j] >= th) begin
            e[j] = 1'b1;
            pm[j] = (md == 2) ? pm[j] - th : 0;
         end else if (md == 1) begin
            pm[j] = pm[j] - (pm[j] >>> lk);
         end
      end
      return e;
   endfunction

   task automatic step(int md, int lk, int th, string tag);
      int cnt;
      logic [N_NEU-1:0] e;
      @(negedge clk);
      cfg_mode = 2'(md); cfg_leak = 3'(lk); cfg_thr = W_P'(th);
      ts_valid = 1'b1;
      while (!ev_ready) @(negedge clk);
      @(negedge clk);
      ts_valid = 1'b0;
      cnt = 0;
      while (!out_vld) begin cnt++; @(negedge clk); end
      chk(cnt == 2, "R6 result latency", cnt, 2);
      e = model_step(md, lk, th);
      chk(out_spk == e, tag, int'(out_spk), int'(e));
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      clear_model();
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      logic [N_NEU-1:0] e;
      rst_n = 1'b0; cfg_mode = '0; cfg_leak = '0; cfg_thr = W_P'(1);
      wl_valid = 1'b0; wl_row = '0; wl_lane = '0; wl_data = '0;
      ev_valid = 1'b0; ev_idx = '0; ts_valid = 1'b0;
      clear_model();
      repeat (3) @(negedge clk);
      chk(ev_ready == 1'b1, "R1 ready after reset", int'(ev_ready), 1);
      chk(out_vld == 1'b0, "R1 out_vld after reset", int'(out_vld), 0);
      chk(out_spk == '0, "R1 out_spk after reset", int'(out_spk), 0);
      rst_n = 1'b1;
      @(negedge clk);
      step(0, 0, 1, "R1 no spikes from zeroed potentials");

      // weight pattern spread over -4..8
      for (int i = 0; i < N_IN; i++)
         for (int j = 0; j < N_NEU; j++)
            load_w(i, j, ((i*5 + j*3) % 13) - 4);

      // vector table walk
      for (int v = 0; v < 8; v++) begin
         string tag;
         case (TBL[v].md)
            2'd0: tag = "R3 R6 R7 table";
            2'd1: tag = "R3 R6 R8 table";
            2'd2: tag = "R3 R6 R9 table";
            default: tag = "R3 R6 R11 table";
         endcase
         for (int r = 0; r < int'(TBL[v].rp); r++)
            for (int i = 0; i < N_IN; i++)
               if (TBL[v].msk[i]) spike(i);
         step(int'(TBL[v].md), int'(TBL[v].lk), int'($signed(TBL[v].th)), tag);
      end

      // R10: spike and step offered together, then a spike during evaluation
      cfg_mode = 2'd0; cfg_leak = '0; cfg_thr = W_P'(3);
      @(negedge clk);
      ev_valid = 1'b1; ev_idx = 2'd1; ts_valid = 1'b1;
      @(negedge clk);
      ev_valid = 1'b0;
      for (int j = 0; j < N_NEU; j++) pm[j] = sat(pm[j] + wm[1][j]);
      repeat (3) @(negedge clk);
      chk(ev_ready == 1'b1, "R10 idle after spike", int'(ev_ready), 1);
      @(negedge clk);
      ts_valid = 1'b0;
      ev_valid = 1'b1; ev_idx = 2'd2;
      chk(ev_ready == 1'b0, "R10 ready low in eval", int'(ev_ready), 0);
      @(negedge clk);
      chk(ev_ready == 1'b0, "R10 ready low in eval", int'(ev_ready), 0);
      @(negedge clk);
      e = model_step(0, 0, 3);
      chk(out_vld == 1'b1, "R10 step after spike", int'(out_vld), 1);
      chk(out_spk == e, "R10 spike applied before step", int'(out_spk), int'(e));
      @(negedge clk);
      ev_valid = 1'b0;
      for (int j = 0; j < N_NEU; j++) pm[j] = sat(pm[j] + wm[2][j]);
      repeat (3) @(negedge clk);
      step(0, 0, 3, "R10 held spike applied after eval");

      // R2: a single loaded weight reaches only its own column
      do_reset();
      load_w(1, 2, 20);
      spike(1);
      step(0, 0, 20, "R2 column placement");
      chk(out_spk == 4'b0100, "R2 only neuron 2 fires", int'(out_spk), 4);

      // R4: saturation at both limits
      load_w(0, 0, 31);
      for (int n = 0; n < 17; n++) spike(0);
      step(0, 0, PMAX, "R4 positive clamp fires at max");
      chk(out_spk[0] == 1'b1, "R4 positive clamp", int'(out_spk[0]), 1);
      load_w(0, 0, -32);
      for (int n = 0; n < 17; n++) spike(0);
      step(2, 0, 1, "R4 negative clamp no wrap");
      chk(out_spk[0] == 1'b0, "R4 negative clamp", int'(out_spk[0]), 0);
      load_w(0, 0, 31);
      for (int n = 0; n < 16; n++) spike(0);
      step(0, 0, -1, "R4 recovery from minimum");

      summary();
   end
endmodule